// File: doc/BRIEF.md
# Line Brownout Peak-Sample Monitor

This block watches the rectified AC line through a digitized high-voltage sense word and decides whether the power stage may switch. Within each sampling window it keeps the largest accepted sample. At the end of every window that peak is copied into a peak register. A separate hold timer copies the peak register into a held value at its own fixed period. Every decision and every output is taken from the held value only.

The enable decision has hysteresis. The held line must reach the brown-in level before switching is allowed. Once switching, it stops only after the held line has stayed under the lower brownout level for a debounce time. That debounce is longer when the light-load flag is set, and the sampling window also stretches under light load. In parallel, a current-limit code for the cycle-by-cycle comparator falls linearly as the held line rises, and it is clamped at both ends of its range. All levels, limits and times are parameters in input units and clock cycles.

Line samples arrive on a valid/ready stream. `line_ready` is low during reset and stays high afterwards, so the block never applies back-pressure. A sample counts only in a cycle where both `line_valid` and `line_ready` are high. The light-load flag and both outputs are plain level signals.

Top module: `line_bo_monitor`

## Requirements
- R1: While reset is active, `pwm_enable` is 0, `line_ready` is 0 and `ilim_code` equals ILIM_HI.
- R2: At the end of each sampling window, the peak register takes the largest sample accepted in that window. A sample offered with `line_valid` low has no effect.
- R3: The sampling window is SAMPLE_N clocks when `light_load` is 0 and SAMPLE_LL clocks when it is 1.
- R4: Every HOLD_CYC clocks, the held value is loaded from the peak register. The enable decision and `ilim_code` depend only on the held value, so a new input can reach them no sooner than two clocks later.
- R5: When `pwm_enable` is 0, it rises on a hold update whose held value is at or above BI_LVL.
- R6: When `pwm_enable` is 1 and the held value is at or above BO_LVL, it stays 1. When `pwm_enable` is 0 and the held value is below BI_LVL, it stays 0.
- R7: With `light_load` 0, `pwm_enable` falls after the held value has been below BO_LVL for DEB_N consecutive clocks.
- R8: With `light_load` 1, the required count is DEB_LL clocks instead.
- R9: A held value at or above BO_LVL during the debounce clears the count, so the next low period starts counting from zero.
- R10: `ilim_code` is ILIM_HI when held ≤ LINE_LO and ILIM_LO when held ≥ LINE_HI. In between it is ILIM_HI − floor((held − LINE_LO)·(ILIM_HI − ILIM_LO)/(LINE_HI − LINE_LO)).
- R11: `line_ready` is 1 in every cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_valid | input | 1 | Line sample offered |
| line_ready | output | 1 | Sample accepted (high after reset) |
| line_data | input | W | Rectified line level, one LSB per input unit |
| light_load | input | 1 | Light-load flag: longer window and debounce |
| pwm_enable | output | 1 | Power stage allowed to switch |
| ilim_code | output | CW | Current-limit level for the peak comparator |

## Verification
On every cycle, the assertions check four things. An enable rise follows a held value at or above brown-in. An enable fall follows a held value below brownout. The held value moves only on a hold update. An accepted sample never exceeds the running window peak. They also keep the limit code inside its two clamps.

Only the bench scenarios can show the timing of whole sequences:
- whether the two debounce lengths really differ;
- whether a short recovery resets the debounce;
- whether the window stretches under light load, shown with spikes spaced wider than the normal window;
- whether the linear mapping gives the right values at chosen line levels.

// File: rtl/lbo_pkg.sv
package lbo_pkg;
  typedef enum logic {
    LINE_OFF = 1'b0,
    LINE_ON  = 1'b1
  } line_state_e;
endpackage

// File: rtl/lbo_peak_sampler.sv
module lbo_peak_sampler #(
  parameter int W         = 9,
  parameter int SAMPLE_N  = 220,
  parameter int SAMPLE_LL = 880,
  parameter int HOLD_CYC  = 650
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_fire,
  input  logic [W-1:0] in_data,
  input  logic         light_load,
  output logic [W-1:0] held,
  output logic         upd
);
  localparam int WIN_MAX = (SAMPLE_LL > SAMPLE_N) ? SAMPLE_LL : SAMPLE_N;
  localparam int WCW     = $clog2(WIN_MAX + 1);
  localparam int HCW     = $clog2(HOLD_CYC + 1);

  logic [WCW-1:0] win_cnt, win_lim;
  logic [HCW-1:0] hold_cnt;
  logic [W-1:0]   cur_pk, cand, pk_q;
  logic           win_end;

  assign win_lim = light_load ? WCW'(SAMPLE_LL) : WCW'(SAMPLE_N);
  assign win_end = (win_cnt >= (win_lim - WCW'(1)));
  assign cand    = (in_fire && (in_data > cur_pk)) ? in_data : cur_pk;

  // window peak capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      cur_pk  <= '0;
      pk_q    <= '0;
    end else if (win_end) begin
      pk_q    <= cand;
      cur_pk  <= '0;
      win_cnt <= '0;
    end else begin
      cur_pk  <= cand;
      win_cnt <= win_cnt + WCW'(1);
    end
  end

  // independent hold / update timer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
      held     <= '0;
      upd      <= 1'b0;
    end else if (hold_cnt == HCW'(HOLD_CYC - 1)) begin
      hold_cnt <= '0;
      held     <= pk_q;
      upd      <= 1'b1;
    end else begin
      hold_cnt <= hold_cnt + HCW'(1);
      upd      <= 1'b0;
    end
  end

  p_peak_covers_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !win_end) |=> (cur_pk >= $past(in_data)));

  p_held_only_on_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |-> $stable(held));
endmodule

// File: rtl/lbo_judge.sv
module lbo_judge
  import lbo_pkg::*;
#(
  parameter int W      = 9,
  parameter int BO_LVL = 144,
  parameter int BI_LVL = 161,
  parameter int DEB_N  = 75000,
  parameter int DEB_LL = 235000
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] held,
  input  logic         upd,
  input  logic         light_load,
  output logic         pwm_en
);
  localparam int DEB_MAX          = (DEB_LL > DEB_N) ? DEB_LL : DEB_N;
  localparam int DCW              = $clog2(DEB_MAX + 1);
  localparam logic [W-1:0] BO_W   = W'(BO_LVL);
  localparam logic [W-1:0] BI_W   = W'(BI_LVL);

  line_state_e    st;
  logic [DCW-1:0] deb_cnt, deb_nxt, deb_lim;
  logic           below;

  assign below   = (held < BO_W);
  assign deb_lim = light_load ? DCW'(DEB_LL) : DCW'(DEB_N);
  assign deb_nxt = deb_cnt + DCW'(1);
  assign pwm_en  = (st == LINE_ON);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= LINE_OFF;
      deb_cnt <= '0;
    end else begin
      case (st)
        LINE_OFF: begin
          deb_cnt <= '0;
          if (upd && (held >= BI_W)) st <= LINE_ON;
        end
        default: begin
          if (!below) begin
            deb_cnt <= '0;
          end else if (deb_nxt >= deb_lim) begin
            st      <= LINE_OFF;
            deb_cnt <= '0;
          end else begin
            deb_cnt <= deb_nxt;
          end
        end
      endcase
    end
  end

  p_rise_needs_brownin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_en) |-> ($past(held) >= BI_W));

  p_fall_needs_brownout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_en) |-> ($past(held) < BO_W));
endmodule

// File: rtl/lbo_ilim_map.sv
module lbo_ilim_map #(
  parameter int W       = 9,
  parameter int CW      = 9,
  parameter int LINE_LO = 122,
  parameter int LINE_HI = 366,
  parameter int ILIM_HI = 460,
  parameter int ILIM_LO = 390
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  held,
  output logic [CW-1:0] code
);
  localparam int SPAN = LINE_HI - LINE_LO;
  localparam int DROP = ILIM_HI - ILIM_LO;
  localparam logic [W-1:0]  LO_W  = W'(LINE_LO);
  localparam logic [W-1:0]  HI_W  = W'(LINE_HI);
  localparam logic [CW-1:0] CHI_W = CW'(ILIM_HI);
  localparam logic [CW-1:0] CLO_W = CW'(ILIM_LO);

  logic [31:0] offs, scaled;

  always_comb begin
    offs   = 32'(held) - 32'(LINE_LO);
    scaled = (offs * 32'(DROP)) / 32'(SPAN);
    if (held <= LO_W)      code = CHI_W;
    else if (held >= HI_W) code = CLO_W;
    else                   code = CW'(32'(ILIM_HI) - scaled);
  end

  p_code_in_clamps_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (code >= CLO_W) && (code <= CHI_W));
endmodule

// File: rtl/line_bo_monitor.sv
module line_bo_monitor #(
  parameter int W         = 9,
  parameter int CW        = 9,
  parameter int SAMPLE_N  = 220,
  parameter int SAMPLE_LL = 880,
  parameter int HOLD_CYC  = 650,
  parameter int BO_LVL    = 144,
  parameter int BI_LVL    = 161,
  parameter int DEB_N     = 75000,
  parameter int DEB_LL    = 235000,
  parameter int LINE_LO   = 122,
  parameter int LINE_HI   = 366,
  parameter int ILIM_HI   = 460,
  parameter int ILIM_LO   = 390
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_valid,
  output logic          line_ready,
  input  logic [W-1:0]  line_data,
  input  logic          light_load,
  output logic          pwm_enable,
  output logic [CW-1:0] ilim_code
);
  logic [W-1:0] held;
  logic         upd;
  logic         in_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) line_ready <= 1'b0;
    else        line_ready <= 1'b1;
  end

  assign in_fire = line_valid && line_ready;

  lbo_peak_sampler #(.W(W), .SAMPLE_N(SAMPLE_N), .SAMPLE_LL(SAMPLE_LL),
                     .HOLD_CYC(HOLD_CYC)) u_samp (
    .clk(clk), .rst_n(rst_n), .in_fire(in_fire), .in_data(line_data),
    .light_load(light_load), .held(held), .upd(upd));

  lbo_judge #(.W(W), .BO_LVL(BO_LVL), .BI_LVL(BI_LVL), .DEB_N(DEB_N),
              .DEB_LL(DEB_LL)) u_judge (
    .clk(clk), .rst_n(rst_n), .held(held), .upd(upd),
    .light_load(light_load), .pwm_en(pwm_enable));

  lbo_ilim_map #(.W(W), .CW(CW), .LINE_LO(LINE_LO), .LINE_HI(LINE_HI),
                 .ILIM_HI(ILIM_HI), .ILIM_LO(ILIM_LO)) u_map (
    .clk(clk), .rst_n(rst_n), .held(held), .code(ilim_code));

  p_ready_after_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> line_ready);
endmodule

// File: tb/line_bo_monitor_bench.sv
module line_bo_monitor_bench;
  localparam int CLK_P = 10;
  localparam int W = 9;
  localparam int CW = 9;

  typedef struct packed {
    logic [W-1:0]  lvl;
    logic          ll;
    logic          en;
    logic [CW-1:0] code;
  } row_t;

  // expected codes: 460 - floor((lvl-122)*70/244), clamped to [390,460]
  localparam row_t TBL [12] = '{
    '{9'd150, 1'b0, 1'b0, 9'd452},
    '{9'd161, 1'b0, 1'b1, 9'd449},
    '{9'd244, 1'b0, 1'b1, 9'd425},
    '{9'd366, 1'b0, 1'b1, 9'd390},
    '{9'd450, 1'b0, 1'b1, 9'd390},
    '{9'd300, 1'b1, 1'b1, 9'd409},
    '{9'd150, 1'b0, 1'b1, 9'd452},
    '{9'd144, 1'b0, 1'b1, 9'd454},
    '{9'd143, 1'b0, 1'b0, 9'd454},
    '{9'd155, 1'b0, 1'b0, 9'd451},
    '{9'd200, 1'b1, 1'b1, 9'd438},
    '{9'd100, 1'b0, 1'b0, 9'd460}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_valid = 1'b0;
  logic line_ready;
  logic [W-1:0] line_data = '0;
  logic light_load = 1'b0;
  logic pwm_enable;
  logic [CW-1:0] ilim_code;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  line_bo_monitor #(.W(W), .CW(CW), .SAMPLE_N(4), .SAMPLE_LL(16), .HOLD_CYC(10),
    .BO_LVL(144), .BI_LVL(161), .DEB_N(40), .DEB_LL(120), .LINE_LO(122),
    .LINE_HI(366), .ILIM_HI(460), .ILIM_LO(390)) u_line_bo_monitor (
    .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
    .line_data(line_data), .light_load(light_load), .pwm_enable(pwm_enable),
    .ilim_code(ilim_code));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_lvl(input int lvl, input bit ll);
    line_valid = 1'b1;
    line_data  = W'(lvl);
    light_load = ll;
  endtask

  // one spike of 200 every 'per' clocks, 100 otherwise; optionally check code each clock
  task automatic spikes(input int per, input int n, input bit watch, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      line_valid = 1'b1;
      line_data  = (i % per == 0) ? W'(200) : W'(100);
      @(negedge clk);
      if (watch && (ilim_code != 9'd438 || !pwm_enable)) bad++;
    end
    if (watch) chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    cyc(3);
    chk(pwm_enable == 1'b0, "R1 enable in reset", pwm_enable, 0);
    chk(line_ready == 1'b0, "R1 ready in reset", line_ready, 0);
    chk(ilim_code == 9'd460, "R1 code in reset", ilim_code, 460);
    rst_n = 1'b1;
    cyc(1);
    chk(line_ready == 1'b1, "R11 ready after reset", line_ready, 1);

    // table walk: R5 R6 R7 R8 R10
    for (int r = 0; r < 12; r++) begin
      set_lvl(int'(TBL[r].lvl), TBL[r].ll);
      cyc(300);
      chk(pwm_enable == TBL[r].en, $sformatf("R5/R6 row %0d enable", r),
          pwm_enable, TBL[r].en);
      chk(ilim_code == TBL[r].code, $sformatf("R10 row %0d code", r),
          ilim_code, TBL[r].code);
      chk(line_ready == 1'b1, "R11 ready held", line_ready, 1);
    end

    // R2: samples without valid are ignored
    line_valid = 1'b0; line_data = W'(400); light_load = 1'b0;
    cyc(200);
    chk(pwm_enable == 1'b0, "R2 invalid sample ignored enable", pwm_enable, 0);
    chk(ilim_code == 9'd460, "R2 invalid sample ignored code", ilim_code, 460);

    // R2: window peak captures a sparse spike
    light_load = 1'b0;
    spikes(4, 200, 1'b0, "");
    spikes(4, 100, 1'b1, "R2 peak of spike per window");

    // R3: under light load a spike every 8 clocks is still seen in each window
    light_load = 1'b1;
    spikes(8, 200, 1'b0, "");
    spikes(8, 200, 1'b1, "R3 light-load window length");

    // R4: change is not visible one clock later, visible after a hold period
    set_lvl(300, 1'b0);
    cyc(1);
    chk(ilim_code == 9'd438, "R4 no immediate code change", ilim_code, 438);
    cyc(20);
    chk(ilim_code == 9'd409, "R4 code after hold update", ilim_code, 409);

    // R7: normal debounce
    set_lvl(130, 1'b0);
    cyc(35);
    chk(pwm_enable == 1'b1, "R7 still on inside normal debounce", pwm_enable, 1);
    cyc(35);
    chk(pwm_enable == 1'b0, "R7 off after normal debounce", pwm_enable, 0);

    set_lvl(200, 1'b0);
    cyc(40);
    chk(pwm_enable == 1'b1, "R5 brown-in again", pwm_enable, 1);

    // R8: light-load debounce
    set_lvl(130, 1'b1);
    cyc(100);
    chk(pwm_enable == 1'b1, "R8 still on inside light-load debounce", pwm_enable, 1);
    cyc(80);
    chk(pwm_enable == 1'b0, "R8 off after light-load debounce", pwm_enable, 0);

    // R9: short dips that recover clear the count
    set_lvl(200, 1'b0);
    cyc(60);
    chk(pwm_enable == 1'b1, "R9 enabled before dips", pwm_enable, 1);
    for (int k = 0; k < 4; k++) begin
      set_lvl(130, 1'b0); cyc(20);
      set_lvl(200, 1'b0); cyc(25);
    end
    chk(pwm_enable == 1'b1, "R9 dips never reach debounce", pwm_enable, 1);

    // R1: reset in mid-run
    rst_n = 1'b0;
    cyc(2);
    chk(pwm_enable == 1'b0, "R1 enable after mid-run reset", pwm_enable, 0);
    chk(ilim_code == 9'd460, "R1 code after mid-run reset", ilim_code, 460);
    chk(line_ready == 1'b0, "R1 ready after mid-run reset", line_ready, 0);
    rst_n = 1'b1;
    cyc(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule